// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is one output-compare channel of a general-purpose timer. It watches the value and counting direction of a counter that lives outside it and compares that value against a compare value. Eight selectable modes shape an active-high reference waveform from the comparison: hold, set/clear/toggle on a hit, a forced level, or one of two direction-aware PWM shapes. The block also produces a pin output whose sense is chosen by a polarity bit.

The compare value is written through a simple write strobe. The block keeps two copies of it: a write-side buffer and a working (shadow) copy. The working copy is the only one used for comparison. With buffering off, a write goes straight into both copies. With buffering on, a write lands only in the buffer, and the working copy takes the buffer's content on each update-event strobe. That lets software change the duty cycle without glitches at a period boundary.

The control word holds mode, buffer enable, channel direction and polarity. It is loaded as a whole by its own strobe. A non-zero direction select marks the channel as an input, and the output logic then freezes both outputs.

Top module: `oc_channel`

## Requirements
- R1: After reset, `ref_o`, `pin_o` and `cmp_rdata_o` are 0. The control word is zero: mode 000, buffer off, direction 0 (output), polarity 0.
- R2: In mode 000 (hold), `ref_o` keeps its level whatever the counter does.
- R3: Mode 001 drives `ref_o` high on the edge after `cnt_i` equals the working compare value. Mode 010 drives it low in the same case. Otherwise the level holds.
- R4: Mode 011 inverts `ref_o` on the edge after each cycle in which `cnt_i` equals the working compare value.
- R5: Mode 100 drives `ref_o` low and mode 101 drives it high, one edge after the mode is in force, independent of the counter.
- R6: In mode 110, the level is active when `cnt_i` < compare while counting up (`cnt_down_i`=0), and when `cnt_i` <= compare while counting down. Mode 111 gives the inverse level.
- R7: In a PWM mode, `ref_o` takes the new level only in three cases: the raw comparison result (the mode-110 level) differs from the previous cycle's; the previous cycle's mode was 000; or the previous cycle's mode was the other PWM mode. After entry from modes 001 to 101, the level holds until the comparison changes.
- R8: With buffering off, a compare write updates the working value and `cmp_rdata_o` on the next edge.
- R9: With buffering on, a compare write changes only the buffer (`cmp_rdata_o` shows it). The working value takes the buffer's content on each edge where `upd_i` is high, and is otherwise unchanged.
- R10: While the direction select is non-zero, `ref_o` and `pin_o` hold their levels.
- R11: In output direction, `pin_o` equals the newly registered `ref_o` XOR the polarity bit in force at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Counter value |
| cnt_down_i | input | 1 | 1 while the counter counts down |
| upd_i | input | 1 | Update-event strobe |
| cmp_wr_i | input | 1 | Compare-value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| cmp_rdata_o | output | CNT_W | Compare value read-back (buffer side) |
| ctrl_wr_i | input | 1 | Control-word write strobe |
| ctrl_mode_i | input | 3 | Output mode to load |
| ctrl_buf_en_i | input | 1 | Compare buffering enable to load |
| ctrl_dir_i | input | 2 | Direction select to load (0 = output) |
| ctrl_pol_i | input | 1 | Pin polarity to load (1 = inverted) |
| ref_o | output | 1 | Active-high reference output |
| pin_o | output | 1 | Polarity-adjusted pin output |

## Verification
The hardest situation to reach is the PWM level rule of R7. A PWM mode must be entered from a forced level while the counter stands still. The level must then stay put until the comparison flips, and it must take effect at once when the mode is entered from hold or from the other PWM mode. The stimulus parks the counter, forces the opposite level, switches the mode, and only then steps the counter across the compare value. A full sweep then covers every mode, every compare value and both directions with a narrow counter, checked against a cycle model built from the requirements. Buffered reloads are tested with writes and update strobes in the same and in different cycles.

// File: rtl/oc_pkg.sv
package oc_pkg;

    typedef enum logic [2:0] {
        OC_HOLD      = 3'd0,
        OC_SET_HIT   = 3'd1,
        OC_CLR_HIT   = 3'd2,
        OC_FLIP_HIT  = 3'd3,
        OC_FORCE_LO  = 3'd4,
        OC_FORCE_HI  = 3'd5,
        OC_PWM_A     = 3'd6,
        OC_PWM_B     = 3'd7
    } oc_mode_e;

    typedef struct packed {
        oc_mode_e   mode;
        logic       buf_en;
        logic [1:0] dir;
        logic       pol;
    } oc_ctrl_t;

    function automatic logic oc_is_pwm(oc_mode_e m);
        return (m == OC_PWM_A) || (m == OC_PWM_B);
    endfunction

endpackage

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_en,
    input  logic         upd,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic [W-1:0] shadow
);

    typedef struct packed {
        logic [W-1:0] bufv;
        logic [W-1:0] shad;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (buf_en && upd) begin
            st_d.shad = st_q.bufv;
        end
        if (wr) begin
            st_d.bufv = wdata;
            if (!buf_en) begin
                st_d.shad = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.bufv;
    assign shadow = st_q.shad;

endmodule

// File: rtl/oc_ref_next.sv
module oc_ref_next
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  oc_mode_e     mode,
    input  oc_mode_e     mode_prev,
    input  logic [W-1:0] cnt,
    input  logic         down,
    input  logic [W-1:0] cmp,
    input  logic         ref_cur,
    input  logic         raw_prev,
    output logic         ref_nxt,
    output logic         raw_nxt
);

    logic hit;
    logic lvl;
    logic pwm_load;

    always_comb begin
        hit     = (cnt == cmp);
        raw_nxt = down ? (cnt <= cmp) : (cnt < cmp);
        lvl     = (mode == OC_PWM_B) ? ~raw_nxt : raw_nxt;
        pwm_load = (raw_nxt != raw_prev)
                || (mode_prev == OC_HOLD)
                || (oc_is_pwm(mode_prev) && (mode_prev != mode));
        ref_nxt = ref_cur;
        unique case (mode)
            OC_HOLD:     ref_nxt = ref_cur;
            OC_SET_HIT:  if (hit) ref_nxt = 1'b1;
            OC_CLR_HIT:  if (hit) ref_nxt = 1'b0;
            OC_FLIP_HIT: if (hit) ref_nxt = ~ref_cur;
            OC_FORCE_LO: ref_nxt = 1'b0;
            OC_FORCE_HI: ref_nxt = 1'b1;
            default:     if (pwm_load) ref_nxt = lvl;
        endcase
    end

endmodule

// File: rtl/oc_channel.sv
module oc_channel
    import oc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_down_i,
    input  logic             upd_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    output logic [CNT_W-1:0] cmp_rdata_o,
    input  logic             ctrl_wr_i,
    input  logic [2:0]       ctrl_mode_i,
    input  logic             ctrl_buf_en_i,
    input  logic [1:0]       ctrl_dir_i,
    input  logic             ctrl_pol_i,
    output logic             ref_o,
    output logic             pin_o
);

    typedef struct packed {
        logic     refl;
        logic     pin;
        logic     raw;
        oc_mode_e mode_prev;
    } out_st_t;

    oc_ctrl_t         ctrl_d, ctrl_q;
    out_st_t          st_d, st_q;
    logic [CNT_W-1:0] shadow_val;
    logic             ref_nxt;
    logic             raw_nxt;
    logic             out_en;
    oc_mode_e         cur_mode;
    logic             cur_buf_en;
    logic             cur_pol;

    assign cur_mode   = ctrl_q.mode;
    assign cur_buf_en = ctrl_q.buf_en;
    assign cur_pol    = ctrl_q.pol;
    assign out_en     = (ctrl_q.dir == 2'b00);

    oc_cmp_store #(.W(CNT_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .buf_en (ctrl_q.buf_en),
        .upd    (upd_i),
        .wr     (cmp_wr_i),
        .wdata  (cmp_wdata_i),
        .rdata  (cmp_rdata_o),
        .shadow (shadow_val)
    );

    oc_ref_next #(.W(CNT_W)) u_next (
        .mode      (ctrl_q.mode),
        .mode_prev (st_q.mode_prev),
        .cnt       (cnt_i),
        .down      (cnt_down_i),
        .cmp       (shadow_val),
        .ref_cur   (st_q.refl),
        .raw_prev  (st_q.raw),
        .ref_nxt   (ref_nxt),
        .raw_nxt   (raw_nxt)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr_i) begin
            ctrl_d.mode   = oc_mode_e'(ctrl_mode_i);
            ctrl_d.buf_en = ctrl_buf_en_i;
            ctrl_d.dir    = ctrl_dir_i;
            ctrl_d.pol    = ctrl_pol_i;
        end
        st_d           = st_q;
        st_d.raw       = raw_nxt;
        st_d.mode_prev = ctrl_q.mode;
        if (out_en) begin
            st_d.refl = ref_nxt;
            st_d.pin  = ref_nxt ^ ctrl_q.pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            st_q   <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            st_q   <= st_d;
        end
    end

    assign ref_o = st_q.refl;
    assign pin_o = st_q.pin;

endmodule

module oc_channel_chk
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic         upd,
    input logic         out_en,
    input oc_mode_e     mode,
    input logic         buf_en,
    input logic         pol,
    input logic [W-1:0] shadow,
    input logic         ref_o,
    input logic         pin_o
);

    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode == OC_HOLD) |=> $stable(ref_o)); // R2

    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode == OC_SET_HIT && cnt == shadow) |=> ref_o); // R3

    AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode == OC_FORCE_LO) |=> !ref_o); // R5

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode == OC_FORCE_HI) |=> ref_o); // R5

    AST_BUF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && !upd) |=> $stable(shadow)); // R9

    AST_INPUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> ($stable(ref_o) && $stable(pin_o))); // R10

    AST_PIN_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |=> (pin_o == (ref_o ^ $past(pol)))); // R11

endmodule

bind oc_channel oc_channel_chk #(.W(CNT_W)) u_oc_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt_i),
    .upd    (upd_i),
    .out_en (out_en),
    .mode   (cur_mode),
    .buf_en (cur_buf_en),
    .pol    (cur_pol),
    .shadow (shadow_val),
    .ref_o  (ref_o),
    .pin_o  (pin_o)
);

// File: tb/test_oc_channel.sv
`timescale 1ns/1ps
module test_oc_channel;

    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         down = 1'b0;
    logic         upd = 1'b0;
    logic         cwr = 1'b0;
    logic [W-1:0] cdat = '0;
    logic [W-1:0] crd;
    logic         kwr = 1'b0;
    logic [2:0]   kmode = '0;
    logic         kbuf = 1'b0;
    logic [1:0]   kdir = '0;
    logic         kpol = 1'b0;
    logic         ref_o, pin_o;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // bench model state
    logic [2:0]   m_mode = '0, m_prev = '0;
    logic         m_buf = 1'b0, m_pol = 1'b0;
    logic [1:0]   m_dir = '0;
    logic [W-1:0] m_bufv = '0, m_shad = '0;
    logic         m_ref = 1'b0, m_pin = 1'b0, m_raw = 1'b0;

    always #2 clk = ~clk;

    oc_channel #(.CNT_W(W)) i_oc_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cnt_down_i(down),
        .upd_i(upd), .cmp_wr_i(cwr), .cmp_wdata_i(cdat), .cmp_rdata_o(crd),
        .ctrl_wr_i(kwr), .ctrl_mode_i(kmode), .ctrl_buf_en_i(kbuf),
        .ctrl_dir_i(kdir), .ctrl_pol_i(kpol), .ref_o(ref_o), .pin_o(pin_o)
    );

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic string mode_tag(logic [2:0] md);
        case (md)
            3'd0: return "R2";
            3'd1, 3'd2: return "R3";
            3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(string rq, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic model_edge();
        logic hit, raw, lvl, nref, load;
        hit  = (cnt == m_shad);
        raw  = down ? (cnt <= m_shad) : (cnt < m_shad);
        lvl  = (m_mode == 3'd7) ? ~raw : raw;
        nref = m_ref;
        load = (raw != m_raw) || (m_prev == 3'd0) ||
               (m_prev[2:1] == 2'b11 && m_prev != m_mode);
        case (m_mode)
            3'd1: if (hit) nref = 1'b1;
            3'd2: if (hit) nref = 1'b0;
            3'd3: if (hit) nref = ~m_ref;
            3'd4: nref = 1'b0;
            3'd5: nref = 1'b1;
            3'd6, 3'd7: if (load) nref = lvl;
            default: nref = m_ref;
        endcase
        if (m_dir == 2'b00) begin
            m_ref = nref;
            m_pin = nref ^ m_pol;
        end
        m_raw  = raw;
        m_prev = m_mode;
        if (m_buf && upd) m_shad = m_bufv;
        if (cwr) begin
            m_bufv = cdat;
            if (!m_buf) m_shad = cdat;
        end
        if (kwr) begin
            m_mode = kmode; m_buf = kbuf; m_dir = kdir; m_pol = kpol;
        end
    endtask

    // one clock: model follows the edge, outputs sampled at the falling edge
    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "ref_o", W'(ref_o), W'(m_ref));
        chk("R11", "pin_o", W'(pin_o), W'(m_pin));
        chk(m_buf ? "R9" : "R8", "cmp_rdata_o", crd, m_bufv);
        cwr = 1'b0; kwr = 1'b0; upd = 1'b0;
    endtask

    task automatic set_ctrl(logic [2:0] md, logic bf, logic [1:0] dr, logic pl);
        kwr = 1'b1; kmode = md; kbuf = bf; kdir = dr; kpol = pl;
        tick();
    endtask

    task automatic wr_cmp(logic [W-1:0] v);
        cwr = 1'b1; cdat = v;
        tick();
    endtask

    initial begin
        #9;
        // R1: reset state
        chk("R1", "ref_o", W'(ref_o), '0);
        chk("R1", "pin_o", W'(pin_o), '0);
        chk("R1", "cmp_rdata_o", crd, '0);
        @(negedge clk);
        rst_n = 1'b1;
        tag = "R1";
        for (int i = 0; i < 4; i++) begin cnt = W'(i); tick(); end

        // Sweep every mode, compare value and direction, both polarities
        for (int md = 0; md < 8; md++) begin
            for (int c = 0; c <= MAXV; c++) begin
                tag = mode_tag(3'(md));
                set_ctrl(3'(md), 1'b0, 2'b00, c[0]);
                wr_cmp(W'(c));
                down = 1'b0;
                for (int v = 0; v <= MAXV; v++) begin cnt = W'(v); tick(); end
                down = 1'b1;
                for (int v = MAXV; v >= 0; v--) begin cnt = W'(v); tick(); end
                down = 1'b0;
            end
        end

        // R7: PWM entry from a forced level holds until the comparison flips
        tag = "R7";
        set_ctrl(3'd0, 1'b0, 2'b00, 1'b0);
        wr_cmp(W'(8));
        cnt = W'(10); tick();
        set_ctrl(3'd5, 1'b0, 2'b00, 1'b0);
        tick();
        set_ctrl(3'd6, 1'b0, 2'b00, 1'b0);
        tick(); tick();
        chk("R7", "ref held after forced entry", W'(ref_o), W'(1));
        cnt = W'(3); tick();
        chk("R7", "ref after compare flip", W'(ref_o), W'(1));
        cnt = W'(12); tick();
        chk("R7", "ref after compare flip back", W'(ref_o), W'(0));
        // switch between the two PWM shapes with counter parked
        set_ctrl(3'd7, 1'b0, 2'b00, 1'b0);
        tick();
        chk("R7", "ref after PWM shape switch", W'(ref_o), W'(1));
        // entry from hold loads at once
        set_ctrl(3'd0, 1'b0, 2'b00, 1'b0);
        tick();
        set_ctrl(3'd6, 1'b0, 2'b00, 1'b0);
        tick();
        chk("R7", "ref after entry from hold", W'(ref_o), W'(0));

        // R9: buffered loading only on update events
        tag = "R9";
        set_ctrl(3'd1, 1'b1, 2'b00, 1'b0);
        set_ctrl(3'd4, 1'b1, 2'b00, 1'b0);
        tick();
        set_ctrl(3'd1, 1'b1, 2'b00, 1'b0);
        wr_cmp(W'(5));
        chk("R9", "read-back shows buffer", crd, W'(5));
        for (int v = 0; v <= MAXV; v++) begin cnt = W'(v); tick(); end
        chk("R9", "ref before update (old shadow 8 hit)", W'(ref_o), W'(1));
        set_ctrl(3'd2, 1'b1, 2'b00, 1'b0);
        cnt = W'(8); tick();
        chk("R9", "clear on old shadow hit", W'(ref_o), W'(0));
        set_ctrl(3'd1, 1'b1, 2'b00, 1'b0);
        cnt = W'(5); tick();
        chk("R9", "no hit on buffered value", W'(ref_o), W'(0));
        upd = 1'b1; cnt = W'(0); tick();
        cnt = W'(5); tick();
        chk("R9", "hit after update", W'(ref_o), W'(1));
        // write and update in the same cycle
        cwr = 1'b1; cdat = W'(2); upd = 1'b1; cnt = W'(0); tick();
        for (int v = 0; v <= MAXV; v++) begin cnt = W'(v); upd = v[0]; tick(); end

        // R8: unbuffered write takes effect next edge
        tag = "R8";
        set_ctrl(3'd2, 1'b0, 2'b00, 1'b1);
        cnt = W'(9); wr_cmp(W'(9));
        tick();
        chk("R8", "clear on new value", W'(ref_o), W'(0));

        // R10: input direction freezes both outputs
        tag = "R10";
        set_ctrl(3'd5, 1'b0, 2'b00, 1'b1);
        tick();
        for (int d = 1; d < 4; d++) begin
            set_ctrl(3'd4, 1'b0, 2'(d), 1'b0);
            for (int v = 0; v <= MAXV; v++) begin cnt = W'(v); tick(); end
            chk("R10", "ref frozen while input", W'(ref_o), W'(1));
            chk("R10", "pin frozen while input", W'(pin_o), W'(0));
            set_ctrl(3'd5, 1'b0, 2'b00, 1'b1);
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule